// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical memory address by adding it to one of four 16-bit segment bases. The segment base is first shifted left by four bit positions. The block holds the four segment registers: code, stack, data and extra. For every access it picks which one applies. The choice depends on the kind of access and on which base or index register supplied the offset. An explicit segment override can replace that choice where the rules allow it.

The address path is purely combinational from the current segment register contents. The requester presents an access kind, an offset-source tag, the offset and an optional override, and reads back the physical address and the identity of the segment that was used.

Segment registers are loaded on the clock edge through two write paths. The general write port reaches the stack, data and extra registers. The code register can only be loaded through a separate control-transfer port. The block does not do the arithmetic that produces the offset, and it does not run the bus cycles.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals the selected segment value times 16 plus `offset`, reduced modulo 2^20 so that any carry out of bit 19 is dropped. It follows input changes with no clock edge in between.
- R2: With `acc_kind` = 0 (instruction fetch), the code segment is used whatever the values of `off_src`, `ovr_valid` and `ovr_seg`.
- R3: With `acc_kind` = 1 (stack access), the stack segment is used, and any override is ignored.
- R4: With `acc_kind` = 2 (data access) and no override, the stack segment is used when `off_src` is 1 (stack pointer) or 2 (base pointer). For every other `off_src` value the data segment is used: 0 instruction pointer, 3 general register, 4 source index, 5 destination index, 6 and 7 reserved.
- R5: With `acc_kind` = 2 and `ovr_valid` = 1, the segment named by `ovr_seg` is used.
- R6: With `acc_kind` = 3 (string destination), the extra segment is used, and any override is ignored.
- R7: A general write with `wr_en` = 1 and `wr_sel` naming extra, stack or data loads `wr_data` into that register at the next rising clock edge. Until that edge, addresses are formed from the old value.
- R8: A general write with `wr_sel` naming the code segment changes nothing. The code register is loaded only with `xfer_data`, at the rising edge that follows `xfer_en` = 1. Both write paths may act in the same cycle.
- R9: While `rst_n` is low, the code register takes `CODE_RST` (default 16'hFFFF) and the other three registers take 0.
- R10: `seg_used` reports the chosen segment with the codes 0 extra, 1 code, 2 stack, 3 data. The `wr_sel` and `ovr_seg` inputs use the same codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_kind | input | 2 | 0 fetch, 1 stack, 2 data, 3 string destination |
| off_src | input | 3 | Register that supplied the offset |
| offset | input | OFF_W | 16-bit offset |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| wr_en | input | 1 | General segment write enable |
| wr_sel | input | 2 | Segment written by the general port |
| wr_data | input | SEG_W | General write value |
| xfer_en | input | 1 | Code segment load enable |
| xfer_data | input | SEG_W | Code segment load value |
| phys_addr | output | ADDR_W | 20-bit physical address |
| seg_used | output | 2 | Segment chosen for this access |

## Verification
The bench builds the block with its default parameters: 16-bit segments and offsets, a shift of 4 and a code reset value of 16'hFFFF. With these values the very first fetch after reset lands at the top 16 bytes of the 1 MB space. A small instruction pointer therefore carries past bit 19 straight away, which makes the wrap of R1 reachable without any register writes. The all-ones segment plus all-ones offset case is also exercised. Random traffic mixes all access kinds, offset sources, overrides and writes on both ports. Because writes and lookups share a cycle, the bench also checks that a written value only appears after the edge.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int NUM_SEG  = 4;
    localparam int SEL_W    = $clog2(NUM_SEG);

    typedef enum logic [1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_STACK  = 2'd1,
        ACC_DATA   = 2'd2,
        ACC_STRDST = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        OSRC_IP   = 3'd0,
        OSRC_SP   = 3'd1,
        OSRC_BP   = 3'd2,
        OSRC_GEN  = 3'd3,
        OSRC_SI   = 3'd4,
        OSRC_DI   = 3'd5,
        OSRC_RSV6 = 3'd6,
        OSRC_RSV7 = 3'd7
    } off_src_e;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int              SEG_W    = 16,
    parameter logic [SEG_W-1:0] CODE_RST = '1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  seg_id_e                         wr_sel,
    input  logic [SEG_W-1:0]                wr_data,
    input  logic                            xfer_en,
    input  logic [SEG_W-1:0]                xfer_data,
    output logic [NUM_SEG-1:0][SEG_W-1:0]   seg_q
);

    logic [NUM_SEG-1:0]              load_en;
    logic [NUM_SEG-1:0][SEG_W-1:0]   load_val;

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        localparam logic [SEG_W-1:0] RST_VAL =
            (i == int'(SEG_CODE)) ? CODE_RST : '0;

        if (i == int'(SEG_CODE)) begin : g_code_path
            // code register: only the control-transfer port reaches it
            assign load_en[i]  = xfer_en;
            assign load_val[i] = xfer_data;
        end else begin : g_gen_path
            assign load_en[i]  = wr_en && (int'(wr_sel) == i);
            assign load_val[i] = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_q[i] <= RST_VAL;
            end else if (load_en[i]) begin
                seg_q[i] <= load_val[i];
            end
        end
    end

    // R8: general port aimed at code leaves it alone
    a_r8_code_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEG_CODE && !xfer_en) |=> $stable(seg_q[SEG_CODE]));

    // R8: transfer port lands in code register
    a_r8_xfer_lands: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |=> (seg_q[SEG_CODE] == $past(xfer_data)));

    // R7: general write lands in the selected register
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != SEG_CODE) |=> (seg_q[$past(wr_sel)] == $past(wr_data)));

endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_addr_pkg::*;
(
    input  acc_kind_e  acc_kind,
    input  off_src_e   off_src,
    input  logic       ovr_valid,
    input  seg_id_e    ovr_seg,
    output seg_id_e    seg_sel
);

    seg_id_e by_source;

    // default segment implied by the offset's origin
    always_comb begin
        unique case (off_src)
            OSRC_SP, OSRC_BP: by_source = SEG_STACK;
            default:          by_source = SEG_DATA;
        endcase
    end

    always_comb begin
        unique case (acc_kind)
            ACC_FETCH:  seg_sel = SEG_CODE;
            ACC_STACK:  seg_sel = SEG_STACK;
            ACC_DATA:   seg_sel = ovr_valid ? ovr_seg : by_source;
            ACC_STRDST: seg_sel = SEG_EXTRA;
            default:    seg_sel = SEG_DATA;
        endcase
    end

endmodule

// File: rtl/seg_addr_adder.sv
module seg_addr_adder #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg_base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] phys_addr
);

    localparam int PAD_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] base_sh;
    logic [ADDR_W-1:0] off_ext;

    assign base_sh   = {seg_base, {SHIFT{1'b0}}};
    assign off_ext   = {{PAD_W{1'b0}}, offset};
    // carry past the top bit falls off the ADDR_W-bit sum
    assign phys_addr = base_sh + off_ext;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int               SEG_W    = 16,
    parameter int               OFF_W    = 16,
    parameter int               SHIFT    = 4,
    parameter logic [SEG_W-1:0] CODE_RST = 16'hFFFF,
    localparam int              ADDR_W   = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        acc_kind,
    input  logic [2:0]        off_src,
    input  logic [OFF_W-1:0]  offset,
    input  logic              ovr_valid,
    input  logic [1:0]        ovr_seg,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic              xfer_en,
    input  logic [SEG_W-1:0]  xfer_data,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [1:0]        seg_used
);

    logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
    seg_id_e                        sel;
    logic [SEG_W-1:0]               seg_base;

    seg_regfile #(
        .SEG_W    (SEG_W),
        .CODE_RST (CODE_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (seg_id_e'(wr_sel)),
        .wr_data   (wr_data),
        .xfer_en   (xfer_en),
        .xfer_data (xfer_data),
        .seg_q     (seg_q)
    );

    seg_select u_sel (
        .acc_kind  (acc_kind_e'(acc_kind)),
        .off_src   (off_src_e'(off_src)),
        .ovr_valid (ovr_valid),
        .ovr_seg   (seg_id_e'(ovr_seg)),
        .seg_sel   (sel)
    );

    assign seg_base = seg_q[sel];
    assign seg_used = sel;

    seg_addr_adder #(
        .SEG_W  (SEG_W),
        .OFF_W  (OFF_W),
        .SHIFT  (SHIFT),
        .ADDR_W (ADDR_W)
    ) u_add (
        .seg_base  (seg_base),
        .offset    (offset),
        .phys_addr (phys_addr)
    );

    // R2: fetches never leave the code segment
    a_r2_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd0) |-> (seg_used == 2'd1));

    // R3: stack kind ignores override
    a_r3_stack_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd1) |-> (seg_used == 2'd2));

    // R5: override obeyed on data accesses
    a_r5_override: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd2 && ovr_valid) |-> (seg_used == ovr_seg));

    // R6: string destination pinned to extra
    a_r6_strdst_extra: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd3) |-> (seg_used == 2'd0));

    // R1: low address bits come straight from the offset
    a_r1_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[SHIFT-1:0] == offset[SHIFT-1:0]);

endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;

    localparam int SEG_W = 16;
    localparam int OFF_W = 16;
    localparam int ADDR_W = 20;
    localparam logic [15:0] CODE_RST = 16'hFFFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        acc_kind = '0;
    logic [2:0]        off_src = '0;
    logic [OFF_W-1:0]  offset = '0;
    logic              ovr_valid = 1'b0;
    logic [1:0]        ovr_seg = '0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = '0;
    logic [SEG_W-1:0]  wr_data = '0;
    logic              xfer_en = 1'b0;
    logic [SEG_W-1:0]  xfer_data = '0;
    logic [ADDR_W-1:0] phys_addr;
    logic [1:0]        seg_used;

    int checks = 0;
    int errors = 0;
    logic [SEG_W-1:0] mdl [4];

    always #2.5 clk = ~clk;

    seg_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .off_src(off_src),
        .offset(offset), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .xfer_en(xfer_en), .xfer_data(xfer_data),
        .phys_addr(phys_addr), .seg_used(seg_used)
    );

    function automatic logic [1:0] exp_seg(logic [1:0] k, logic [2:0] s,
                                           logic ov, logic [1:0] os);
        if (k == 2'd0) return 2'd1;
        if (k == 2'd1) return 2'd2;
        if (k == 2'd3) return 2'd0;
        if (ov) return os;
        if (s == 3'd1 || s == 3'd2) return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [19:0] exp_addr(logic [15:0] sg, logic [15:0] off);
        logic [20:0] full;
        full = {1'b0, sg, 4'h0} + {5'h0, off};
        return full[19:0];
    endfunction

    function automatic string kind_tag(logic [1:0] k, logic ov);
        case (k)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return ov ? "R5" : "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive a lookup (and optional writes) at the falling edge, check, then let the edge pass
    task automatic step(logic [1:0] k, logic [2:0] s, logic [15:0] off,
                        logic ov, logic [1:0] os,
                        logic we, logic [1:0] ws, logic [15:0] wd,
                        logic xe, logic [15:0] xd);
        logic [1:0] es;
        @(negedge clk);
        acc_kind = k; off_src = s; offset = off; ovr_valid = ov; ovr_seg = os;
        wr_en = we; wr_sel = ws; wr_data = wd; xfer_en = xe; xfer_data = xd;
        #1;
        es = exp_seg(k, s, ov, os);
        check({kind_tag(k, ov), " R10 seg"}, 32'(seg_used), 32'(es));
        check("R1 R7 addr", 32'(phys_addr), 32'(exp_addr(mdl[es], off)));
        @(posedge clk);
        if (we && ws != 2'd1) mdl[ws] = wd;
        if (xe) mdl[1] = xd;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        mdl[0] = '0; mdl[1] = CODE_RST; mdl[2] = '0; mdl[3] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R9: during reset, fetch at offset 0 reaches FFFF0
        check("R9 reset code", 32'(phys_addr), 32'h000FFFF0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: other segments zero after reset
        step(2'd2, 3'd3, 16'h1234, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0);
        check("R9 data zero", 32'(phys_addr), 32'h00001234);
        // R1: wrap past 1 MB from reset code segment
        step(2'd0, 3'd0, 16'h0010, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0);
        check("R1 wrap", 32'(phys_addr), 32'h00000000);
        // R2: override ignored on fetch
        step(2'd0, 3'd1, 16'h0003, 1'b1, 2'd3, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0);
        check("R2 fetch ovr", 32'(seg_used), 32'd1);

        // R7: write data seg; same-cycle lookup still sees old
        step(2'd2, 3'd4, 16'h0001, 1'b0, 2'd0, 1'b1, 2'd3, 16'hFFFF, 1'b0, 16'h0);
        step(2'd2, 3'd4, 16'hFFFF, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0);
        check("R7 new data", 32'(phys_addr), 32'h0000FFEF);

        // R8: general write to code ignored
        step(2'd0, 3'd0, 16'h0000, 1'b0, 2'd0, 1'b1, 2'd1, 16'h1000, 1'b0, 16'h0);
        step(2'd0, 3'd0, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0);
        check("R8 code kept", 32'(phys_addr), 32'h000FFFF0);
        // R8: transfer port loads code, together with a general write
        step(2'd0, 3'd0, 16'h0000, 1'b0, 2'd0, 1'b1, 2'd0, 16'h2000, 1'b1, 16'h1000);
        step(2'd0, 3'd0, 16'h0005, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0);
        check("R8 code xfer", 32'(phys_addr), 32'h00010005);
        // R6: destination index in string op uses extra
        step(2'd3, 3'd5, 16'h0004, 1'b1, 2'd3, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0);
        check("R6 strdst", 32'(phys_addr), 32'h00020004);
        // R4: base pointer on data access uses stack
        step(2'd2, 3'd2, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0);
        check("R4 bp stack", 32'(seg_used), 32'd2);
        // R5: override to code on data access
        step(2'd2, 3'd3, 16'h0000, 1'b1, 2'd1, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0);
        check("R5 ovr code", 32'(phys_addr), 32'h00010000);
        // R3: stack kind ignores override
        step(2'd1, 3'd1, 16'h0000, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0);
        check("R3 stack", 32'(seg_used), 32'd2);

        for (int i = 0; i < 3000; i++) begin
            step(2'($urandom), 3'($urandom), 16'($urandom),
                 1'($urandom), 2'($urandom),
                 ($urandom % 3) == 0, 2'($urandom), 16'($urandom),
                 ($urandom % 8) == 0, 16'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule